// File: doc/BRIEF.md
# Multi-Mode 16-Bit Interval Counter

This block is a general-purpose 16-bit counter for a microcontroller-style peripheral set. Everything runs on one system clock. One of four count-enable strobes is selected as the counting source. A power-of-two divider thins that source into count ticks. The divided tick then steps the counter in one of four ways: halted, up to a period value and back to zero, free-running over the full 16-bit range, or up and down between zero and the period in a triangle.

Software sets the block up through a 9-bit control word. The word holds the source select, the divider ratio, the counting mode, a clear action, an interrupt enable and a sticky overflow flag. The period value and the counter itself each have their own write strobe. The counter is always visible on an output. An interrupt request is raised while the flag and the enable are both set.

Top module: `tick_timer16`

## Requirements
- R1: After reset the count is 0, the control read-back is 0 (source 0, divide-by-1, halted, interrupt disabled, flag clear) and the interrupt request is low.
- R2: Control bits [1:0] pick which bit of `src_en` paces counting: code n uses `src_en[n]`. Strobes on the other bits have no effect on the count.
- R3: Control bits [3:2] set the divider. Codes 0, 1, 2 and 3 give one count tick per 1, 2, 4 or 8 selected strobes. The divider restarts from zero after each tick.
- R4: Control bits [5:4] = 0 halt the counter. A control write that selects halt takes effect from the tick after the write edge, and the count then holds.
- R5: Mode code 1 (up): the count rises by one per tick. On the tick where the count is at or above the period it returns to 0 and sets the flag.
- R6: Mode code 2 (free-running): the count rises by one per tick. It goes from 0xFFFF to 0 and sets the flag on that tick.
- R7: Mode code 3 (triangle): the count rises from 0 to the period, then falls to 0, and repeats, so one cycle spans 2×period ticks. The flag sets on each tick that brings the falling count to 0.
- R8: Writing the control word with bit 6 set zeroes the count and the divider and forces the triangle direction to rising. Bit 6 always reads back 0.
- R9: The flag (bit 8) stays set until a control write puts 0 in bit 8. A flag-setting event in the same cycle as such a write wins.
- R10: `irq` is high exactly while the flag and the interrupt enable (bit 7) are both 1.
- R11: A pulse on `cnt_wr` loads `cnt_wdata` into the count at the next edge. This load takes priority over a tick in the same cycle but yields to a clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_en | input | 4 | Candidate count-enable strobes |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 9 | Control word write data |
| ctrl_rdata | output | 9 | Control word read-back |
| period_wr | input | 1 | Period register write strobe |
| period_wdata | input | 16 | Period value |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | 16 | Counter load value |
| count | output | 16 | Current count |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The count and the flag update on the same clock edge as the divided tick that causes them. With divide-by-1 and an enable held high, n edges after a clearing control write give n ticks, and the expected values are counted from that edge. A control write changes the mode only for later edges, so the bench expects one more tick under the old mode at the write edge. `irq` follows the registered flag and enable without delay. Inputs are driven on the falling edge and outputs are read on a later falling edge, after an exact number of rising edges.

// File: rtl/tick_timer16_pkg.sv
package tick_timer16_pkg;

    localparam int CNT_W   = 16;
    localparam int NUM_SRC = 4;
    localparam int SEL_W   = $clog2(NUM_SRC);
    localparam int DIV_W   = 2;
    localparam int PRE_W   = (1 << DIV_W) - 1;

    // control word layout
    localparam int SRC_LSB  = 0;
    localparam int DIV_LSB  = SRC_LSB + SEL_W;
    localparam int MODE_LSB = DIV_LSB + DIV_W;
    localparam int CLR_BIT  = MODE_LSB + 2;
    localparam int IE_BIT   = CLR_BIT + 1;
    localparam int FLAG_BIT = IE_BIT + 1;
    localparam int CTRL_W   = FLAG_BIT + 1;

    typedef enum logic [1:0] {
        MODE_HALT = 2'd0,
        MODE_UP   = 2'd1,
        MODE_FREE = 2'd2,
        MODE_TRI  = 2'd3
    } tmr_mode_e;

    typedef struct packed {
        logic [SEL_W-1:0] src;
        logic [DIV_W-1:0] div;
        tmr_mode_e        mode;
        logic             ie;
        logic             flag;
    } tmr_ctrl_t;

endpackage

// File: rtl/tmr_src_sel.sv
module tmr_src_sel
    import tick_timer16_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    localparam int SW   = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0] src_en,
    input  logic [SW-1:0]    sel,
    output logic             src_tick
);

    logic [N_SRC-1:0] hit;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign hit[i] = src_en[i] && (sel == SW'(i));
    end

    assign src_tick = |hit;

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tick_timer16_pkg::*;
#(
    parameter int DW = DIV_W,
    localparam int CW = (1 << DW) - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          src_tick,
    input  logic [DW-1:0] div_sel,
    input  logic          clr,
    output logic          tick
);

    logic [CW-1:0] div_cnt_d, div_cnt_q;
    logic [CW-1:0] limit;

    always_comb begin
        limit     = CW'((1 << div_sel) - 1);
        tick      = src_tick && (div_cnt_q >= limit);
        div_cnt_d = div_cnt_q;
        if (clr) begin
            div_cnt_d = '0;
        end else if (src_tick) begin
            div_cnt_d = tick ? '0 : div_cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_cnt_q <= '0;
        else        div_cnt_q <= div_cnt_d;
    end

    // R3
    div_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr) |=> (div_cnt_q == '0));

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import tick_timer16_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  tmr_mode_e    mode,
    input  logic [W-1:0] period,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         ovf
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         down;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        ovf  = 1'b0;
        if (clr) begin
            st_d.cnt  = '0;
            st_d.down = 1'b0;
        end else if (load) begin
            st_d.cnt = load_val;
        end else if (tick) begin
            case (mode)
                MODE_UP: begin
                    if (st_q.cnt >= period) begin
                        st_d.cnt = '0;
                        ovf      = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                MODE_FREE: begin
                    st_d.cnt = st_q.cnt + 1'b1;
                    ovf      = (st_q.cnt == {W{1'b1}});
                end
                MODE_TRI: begin
                    if (!st_q.down) begin
                        if (st_q.cnt < period) begin
                            st_d.cnt = st_q.cnt + 1'b1;
                        end else if (st_q.cnt != '0) begin
                            st_d.cnt  = st_q.cnt - 1'b1;
                            ovf       = (st_q.cnt == W'(1));
                            st_d.down = (st_q.cnt != W'(1));
                        end
                    end else begin
                        if (st_q.cnt == '0) begin
                            st_d.down = 1'b0;
                        end else begin
                            st_d.cnt = st_q.cnt - 1'b1;
                            if (st_q.cnt == W'(1)) begin
                                ovf       = 1'b1;
                                st_d.down = 1'b0;
                            end
                        end
                    end
                end
                default: begin
                    st_d = st_q;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    // R4
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HALT && !clr && !load) |=> $stable(cnt));

    // R5
    up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == MODE_UP && !clr && !load && cnt >= period) |=> (cnt == '0));

    // R6
    free_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == MODE_FREE && !clr && !load && cnt == {W{1'b1}}) |=> (cnt == '0));

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

endmodule

// File: rtl/tick_timer16.sv
module tick_timer16
    import tick_timer16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        src_en,
    input  logic              ctrl_wr,
    input  logic [8:0]        ctrl_wdata,
    output logic [8:0]        ctrl_rdata,
    input  logic              period_wr,
    input  logic [15:0]       period_wdata,
    input  logic              cnt_wr,
    input  logic [15:0]       cnt_wdata,
    output logic [15:0]       count,
    output logic              ovf_flag,
    output logic              irq
);

    typedef struct packed {
        tmr_ctrl_t        ctrl;
        logic [CNT_W-1:0] period;
    } top_st_t;

    top_st_t st_d, st_q;

    logic src_tick, tick, clr, ovf;

    assign clr = ctrl_wr && ctrl_wdata[CLR_BIT];

    always_comb begin
        st_d = st_q;
        if (ctrl_wr) begin
            st_d.ctrl.src  = ctrl_wdata[SRC_LSB +: SEL_W];
            st_d.ctrl.div  = ctrl_wdata[DIV_LSB +: DIV_W];
            st_d.ctrl.mode = tmr_mode_e'(ctrl_wdata[MODE_LSB +: 2]);
            st_d.ctrl.ie   = ctrl_wdata[IE_BIT];
            st_d.ctrl.flag = ctrl_wdata[FLAG_BIT];
        end
        if (ovf) begin
            st_d.ctrl.flag = 1'b1;
        end
        if (period_wr) begin
            st_d.period = period_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    tmr_src_sel #(.N_SRC(NUM_SRC)) u_sel (
        .src_en   (src_en),
        .sel      (st_q.ctrl.src),
        .src_tick (src_tick)
    );

    tmr_prescale #(.DW(DIV_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_tick (src_tick),
        .div_sel  (st_q.ctrl.div),
        .clr      (clr),
        .tick     (tick)
    );

    tmr_count_core #(.W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .mode     (st_q.ctrl.mode),
        .period   (st_q.period),
        .clr      (clr),
        .load     (cnt_wr),
        .load_val (cnt_wdata),
        .cnt      (count),
        .ovf      (ovf)
    );

    assign ovf_flag   = st_q.ctrl.flag;
    assign irq        = st_q.ctrl.flag && st_q.ctrl.ie;
    assign ctrl_rdata = {st_q.ctrl.flag, st_q.ctrl.ie, 1'b0,
                         st_q.ctrl.mode, st_q.ctrl.div, st_q.ctrl.src};

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ctrl_wr) |=> ovf_flag);

    // R9
    flag_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf_flag);

endmodule

// File: tb/tick_timer16_tb.sv
module tick_timer16_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_en = '0;
    logic        ctrl_wr = 1'b0;
    logic [8:0]  ctrl_wdata = '0;
    logic [8:0]  ctrl_rdata;
    logic        period_wr = 1'b0;
    logic [15:0] period_wdata = '0;
    logic        cnt_wr = 1'b0;
    logic [15:0] cnt_wdata = '0;
    logic [15:0] count;
    logic        ovf_flag;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    tick_timer16 u_dut (
        .clk(clk), .rst_n(rst_n), .src_en(src_en),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
        .period_wr(period_wr), .period_wdata(period_wdata),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .count(count), .ovf_flag(ovf_flag), .irq(irq)
    );

    // vector: period, ticks, expected count, div, mode, expected flag
    localparam int NV = 11;
    localparam logic [63:0] VEC [NV] = '{
        {16'd5,   16'd3,  16'd3,  11'd0, 2'd0, 2'd1, 1'b0},
        {16'd5,   16'd6,  16'd0,  11'd0, 2'd0, 2'd1, 1'b1},
        {16'd5,   16'd8,  16'd2,  11'd0, 2'd0, 2'd1, 1'b1},
        {16'd5,   16'd10, 16'd10, 11'd0, 2'd0, 2'd2, 1'b0},
        {16'd3,   16'd4,  16'd2,  11'd0, 2'd0, 2'd3, 1'b0},
        {16'd3,   16'd6,  16'd0,  11'd0, 2'd0, 2'd3, 1'b1},
        {16'd3,   16'd7,  16'd1,  11'd0, 2'd0, 2'd3, 1'b1},
        {16'd100, 16'd9,  16'd2,  11'd0, 2'd2, 2'd1, 1'b0},
        {16'd100, 16'd16, 16'd2,  11'd0, 2'd3, 2'd1, 1'b0},
        {16'd100, 16'd5,  16'd2,  11'd0, 2'd1, 2'd1, 1'b0},
        {16'd5,   16'd5,  16'd0,  11'd0, 2'd0, 2'd0, 1'b0}
    };
    localparam string VTAG [NV] = '{"R5", "R5", "R5", "R6", "R7", "R7", "R7",
                                    "R3", "R3", "R3", "R4"};

    function automatic logic [8:0] cfg(input logic [1:0] src, input logic [1:0] dv,
                                       input logic [1:0] md, input logic ie,
                                       input logic fl, input logic cl);
        return {fl, ie, cl, md, dv, src};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctrl(input logic [8:0] v);
        ctrl_wr = 1'b1;
        ctrl_wdata = v;
        step(1);
        ctrl_wr = 1'b0;
    endtask

    task automatic setup(input logic [15:0] per, input logic [8:0] v);
        period_wr = 1'b1;
        period_wdata = per;
        ctrl_wr = 1'b1;
        ctrl_wdata = v;
        step(1);
        period_wr = 1'b0;
        ctrl_wr = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(2);
        // R1 reset state
        chk("R1", {16'd0, count}, 0);
        chk("R1", {23'd0, ctrl_rdata}, 0);
        chk("R1", {31'd0, irq}, 0);
        rst_n = 1'b1;
        step(2);
        chk("R1", {16'd0, count}, 0);

        src_en = 4'b1111;
        for (int i = 0; i < NV; i++) begin
            setup(VEC[i][63:48], cfg(2'd0, VEC[i][4:3], VEC[i][2:1], 1'b0, 1'b0, 1'b1));
            step(int'(VEC[i][47:32]));
            chk(VTAG[i], {16'd0, count}, {16'd0, VEC[i][31:16]});
            chk(VTAG[i], {31'd0, ovf_flag}, {31'd0, VEC[i][0]});
        end

        // R8 clear bit reads back 0
        setup(16'd5, cfg(2'd0, 2'd0, 2'd1, 1'b0, 1'b0, 1'b1));
        chk("R8", {31'd0, ctrl_rdata[6]}, 0);
        chk("R8", {23'd0, ctrl_rdata}, {23'd0, cfg(2'd0, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0)});

        // R4 halt takes effect after the write edge
        step(3);
        chk("R4", {16'd0, count}, 3);
        wr_ctrl(cfg(2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0));
        chk("R4", {16'd0, count}, 4);
        step(5);
        chk("R4", {16'd0, count}, 4);

        // R11 load, R6 wrap from 0xFFFF
        setup(16'd5, cfg(2'd0, 2'd0, 2'd2, 1'b0, 1'b0, 1'b1));
        cnt_wr = 1'b1;
        cnt_wdata = 16'hFFFE;
        step(1);
        cnt_wr = 1'b0;
        chk("R11", {16'd0, count}, 32'hFFFE);
        step(1);
        chk("R6", {16'd0, count}, 32'hFFFF);
        chk("R6", {31'd0, ovf_flag}, 0);
        step(1);
        chk("R6", {16'd0, count}, 0);
        chk("R6", {31'd0, ovf_flag}, 1);

        // R10 irq gating; R9 sticky and cleared by writing 0
        chk("R10", {31'd0, irq}, 0);
        step(3);
        chk("R9", {31'd0, ovf_flag}, 1);
        wr_ctrl(cfg(2'd0, 2'd0, 2'd2, 1'b1, 1'b1, 1'b0));
        chk("R10", {31'd0, irq}, 1);
        wr_ctrl(cfg(2'd0, 2'd0, 2'd2, 1'b1, 1'b0, 1'b0));
        chk("R9", {31'd0, ovf_flag}, 0);
        chk("R10", {31'd0, irq}, 0);

        // R2 source select
        src_en = 4'b0001;
        setup(16'd100, cfg(2'd1, 2'd0, 2'd1, 1'b0, 1'b0, 1'b1));
        step(5);
        chk("R2", {16'd0, count}, 0);
        src_en = 4'b0010;
        step(5);
        chk("R2", {16'd0, count}, 5);
        src_en = 4'b0111;
        setup(16'd100, cfg(2'd3, 2'd0, 2'd1, 1'b0, 1'b0, 1'b1));
        step(4);
        chk("R2", {16'd0, count}, 0);

        // R8 clear forces rising direction
        src_en = 4'b1111;
        setup(16'd3, cfg(2'd0, 2'd0, 2'd3, 1'b0, 1'b0, 1'b1));
        step(5);
        chk("R7", {16'd0, count}, 1);
        wr_ctrl(cfg(2'd0, 2'd0, 2'd3, 1'b0, 1'b0, 1'b1));
        chk("R8", {16'd0, count}, 0);
        step(1);
        chk("R8", {16'd0, count}, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule